// File: doc/BRIEF.md
# Complementary PWM Dead-Time Timebase

This block is the counting core behind a three-phase complementary PWM generator. It runs two main counters in a triangle (up, then down) with a fixed offset between them equal to a programmed dead time. It also runs an auxiliary sub-counter near the crest of the triangle. The downstream compare logic takes its waveform edges from these counters. The block itself produces no waveforms.

Software programs a dead-time value and a half-period (cycle) value through a 16-bit register port, then issues a start. The start checks the two values. A legal pair loads the counters: the leading counter begins at the dead-time value and the trailing counter at zero. An illegal pair sets a sticky error flag, and the counters stay stopped. Counting advances only on cycles where the count enable is high. A one-cycle strobe marks every reversal of direction. Register writes made while the counters run are held back and take effect at the next start.

Top module: `cpwm_timebase`

## Requirements
- R1: After reset, both configuration registers read 0xFFFF. Both main counters, the sub-counter, the direction flag (`down_o`, 0 = counting up), the sub-counter direction, the turnaround strobe and the error flag are all 0.
- R2: A write with `wr_i` high and `be_i` = 2'b11 stores `wdata_i` in the register chosen by `addr_i` (0 = dead time, 1 = cycle). A write with any other `be_i` value leaves both registers unchanged. `rdata_o` shows the register chosen by `addr_i` combinationally.
- R3: A start is legal when cycle >= 2*dead + 3 and cycle + dead <= 0xFFFF. On the clock after a legal start, `cnt_a_o` equals the dead-time value, `cnt_b_o` is 0, `down_o` is 0, and counting begins.
- R4: On each clock with `en_i` high, the main counters move one step in the current direction. The leading counter reverses at cycle + dead (crest) and at dead (trough). A reversal step moves away from the extreme value. With `en_i` low, every counter output holds its value.
- R5: While running, `cnt_a_o - cnt_b_o` equals the dead-time value latched at the last start.
- R6: `turn_o` is high for exactly the one clock that follows each reversal step, at both crest and trough. It is not raised by a start.
- R7: On the enabled step where the leading counter moves up from the cycle value, the sub-counter loads cycle + dead and begins counting down (`sub_up_o` = 0). When it equals the cycle value it switches to counting up (`sub_up_o` = 1). It stops once it is back at cycle + dead and holds that value with `sub_up_o` = 0.
- R8: A start with an illegal pair sets `cfg_err_o`, which stays high until reset. The same start clears the counters and stops them. A later legal start runs normally while `cfg_err_o` stays high.
- R9: Register writes made while the counters run do not change the count profile. The new values apply from the next start.
- R10: `clr_i` stops and zeroes the counters on the next clock. If `clr_i` and `start_i` are high together, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Count enable |
| start_i | input | 1 | Start/restart pulse |
| clr_i | input | 1 | Stop-and-clear pulse |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 dead time, 1 cycle |
| be_i | input | 2 | Byte enables; only 2'b11 writes |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` |
| cnt_a_o | output | 16 | Leading main counter |
| cnt_b_o | output | 16 | Trailing main counter |
| sub_cnt_o | output | 16 | Crest sub-counter |
| down_o | output | 1 | Main counter direction, 1 = down |
| sub_up_o | output | 1 | Sub-counter direction, 1 = up |
| turn_o | output | 1 | Turnaround strobe |
| cfg_err_o | output | 1 | Sticky configuration error |

## Verification
Every counter, flag and strobe result is registered. It appears one clock after the edge that sampled the start, clear or enabled step. Read data is combinational and is due in the same cycle as the address. The bench drives inputs at the falling edge and samples on the next falling edge. A separate index counts enabled steps since the start, and the closed-form triangle, strobe and sub-counter values are computed from that index. Read-back is sampled one time unit after the address changes.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  typedef enum logic {
    SEL_DEAD  = 1'b0,
    SEL_CYCLE = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/cpwm_regs.sv
module cpwm_regs
  import cpwm_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_i,
  input  logic           addr_i,
  input  logic [W/8-1:0] be_i,
  input  logic [W-1:0]   wdata_i,
  output logic [W-1:0]   rdata_o,
  output logic [W-1:0]   dead_o,
  output logic [W-1:0]   cyc_o
);
  logic [W-1:0] dead_q, cyc_q;
  logic         full_wr;

  // only full-width accesses are accepted
  assign full_wr = wr_i && (&be_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dead_q <= '1;
      cyc_q  <= '1;
    end else if (full_wr) begin
      unique case (reg_sel_e'(addr_i))
        SEL_DEAD:  dead_q <= wdata_i;
        SEL_CYCLE: cyc_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  assign rdata_o = (reg_sel_e'(addr_i) == SEL_CYCLE) ? cyc_q : dead_q;
  assign dead_o  = dead_q;
  assign cyc_o   = cyc_q;

  a_r2_partial_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !(&be_i)) |=> ($stable(dead_q) && $stable(cyc_q)));
endmodule

// File: rtl/cpwm_main_cnt.sv
module cpwm_main_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         stop_i,
  input  logic         load_i,
  input  logic         en_i,
  input  logic [W-1:0] load_val_i,
  input  logic [W-1:0] dead_i,
  input  logic [W-1:0] cyc_i,
  input  logic [W-1:0] top_i,
  output logic [W-1:0] cnt_a_o,
  output logic [W-1:0] cnt_b_o,
  output logic         down_o,
  output logic         turn_o,
  output logic         run_o,
  output logic         tick_o,
  output logic         sub_load_o
);
  logic [W-1:0] a_q, b_q;
  logic         down_q, turn_q, run_q;
  logic         tick;

  assign tick = run_q && en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0; b_q <= '0; down_q <= 1'b0; turn_q <= 1'b0; run_q <= 1'b0;
    end else if (stop_i) begin
      a_q <= '0; b_q <= '0; down_q <= 1'b0; turn_q <= 1'b0; run_q <= 1'b0;
    end else if (load_i) begin
      a_q <= load_val_i; b_q <= '0; down_q <= 1'b0; turn_q <= 1'b0; run_q <= 1'b1;
    end else begin
      turn_q <= 1'b0;
      if (tick) begin
        if (!down_q) begin
          if (a_q == top_i) begin
            down_q <= 1'b1; turn_q <= 1'b1;
            a_q <= a_q - 1'b1; b_q <= b_q - 1'b1;
          end else begin
            a_q <= a_q + 1'b1; b_q <= b_q + 1'b1;
          end
        end else begin
          if (a_q == dead_i) begin
            down_q <= 1'b0; turn_q <= 1'b1;
            a_q <= a_q + 1'b1; b_q <= b_q + 1'b1;
          end else begin
            a_q <= a_q - 1'b1; b_q <= b_q - 1'b1;
          end
        end
      end
    end
  end

  assign cnt_a_o    = a_q;
  assign cnt_b_o    = b_q;
  assign down_o     = down_q;
  assign turn_o     = turn_q;
  assign run_o      = run_q;
  assign tick_o     = tick;
  assign sub_load_o = tick && !down_q && (a_q == cyc_i);

  a_r5_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> ((a_q - b_q) == dead_i));
  a_r4_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (a_q >= dead_i && a_q <= top_i));
  a_r6_turn_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    turn_q |=> !turn_q);
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !stop_i && !load_i) |=> ($stable(a_q) && $stable(b_q)));
endmodule

// File: rtl/cpwm_sub_cnt.sv
module cpwm_sub_cnt #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic         tick_i,
  input  logic [W-1:0] cyc_i,
  input  logic [W-1:0] top_i,
  output logic [W-1:0] sub_o,
  output logic         up_o
);
  logic [W-1:0] s_q;
  logic         up_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_q <= '0; up_q <= 1'b0; act_q <= 1'b0;
    end else if (clr_i) begin
      s_q <= '0; up_q <= 1'b0; act_q <= 1'b0;
    end else if (load_i) begin
      s_q <= top_i; up_q <= 1'b0; act_q <= 1'b1;
    end else if (act_q && tick_i) begin
      if (!up_q) begin
        if (s_q == cyc_i) begin
          // match with cycle value: turn from down to up
          if (s_q == top_i) act_q <= 1'b0;
          else begin
            up_q <= 1'b1; s_q <= s_q + 1'b1;
          end
        end else s_q <= s_q - 1'b1;
      end else if (s_q == top_i) begin
        act_q <= 1'b0; up_q <= 1'b0;
      end else s_q <= s_q + 1'b1;
    end
  end

  assign sub_o = s_q;
  assign up_o  = up_q;

  a_r7_sub_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> (s_q >= cyc_i && s_q <= top_i));
  a_r7_turn_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && tick_i && !up_q && !load_i && !clr_i && s_q == cyc_i && s_q != top_i) |=> up_q);
endmodule

// File: rtl/cpwm_timebase.sv
module cpwm_timebase #(
  parameter int unsigned W = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           start_i,
  input  logic           clr_i,
  input  logic           wr_i,
  input  logic           addr_i,
  input  logic [W/8-1:0] be_i,
  input  logic [W-1:0]   wdata_i,
  output logic [W-1:0]   rdata_o,
  output logic [W-1:0]   cnt_a_o,
  output logic [W-1:0]   cnt_b_o,
  output logic [W-1:0]   sub_cnt_o,
  output logic           down_o,
  output logic           sub_up_o,
  output logic           turn_o,
  output logic           cfg_err_o
);
  localparam int unsigned XW = W + 2;

  logic [W-1:0]  dead_reg, cyc_reg;
  logic [W-1:0]  dead_act, cyc_act, top_act;
  logic [XW-1:0] min_cyc;
  logic [W:0]    top_sum;
  logic          legal, load, stop, err_q, run, tick, sub_load;

  cpwm_regs #(.W(W)) u_regs (
    .clk_i, .rst_ni, .wr_i, .addr_i, .be_i, .wdata_i,
    .rdata_o, .dead_o(dead_reg), .cyc_o(cyc_reg)
  );

  assign min_cyc = {1'b0, dead_reg, 1'b0} + XW'(3);
  assign top_sum = {1'b0, cyc_reg} + {1'b0, dead_reg};
  assign legal   = ({2'b00, cyc_reg} >= min_cyc) && !top_sum[W];
  assign load    = start_i && !clr_i && legal;
  assign stop    = clr_i || (start_i && !legal);

  // working copies: register writes reach the counters only at a start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dead_act <= '0; cyc_act <= '0; top_act <= '0; err_q <= 1'b0;
    end else begin
      if (load) begin
        dead_act <= dead_reg;
        cyc_act  <= cyc_reg;
        top_act  <= top_sum[W-1:0];
      end
      if (start_i && !clr_i && !legal) err_q <= 1'b1;
    end
  end

  cpwm_main_cnt #(.W(W)) u_main (
    .clk_i, .rst_ni, .stop_i(stop), .load_i(load), .en_i,
    .load_val_i(dead_reg), .dead_i(dead_act), .cyc_i(cyc_act), .top_i(top_act),
    .cnt_a_o, .cnt_b_o, .down_o, .turn_o, .run_o(run), .tick_o(tick),
    .sub_load_o(sub_load)
  );

  cpwm_sub_cnt #(.W(W)) u_sub (
    .clk_i, .rst_ni, .clr_i(stop || load), .load_i(sub_load), .tick_i(tick),
    .cyc_i(cyc_act), .top_i(top_act), .sub_o(sub_cnt_o), .up_o(sub_up_o)
  );

  assign cfg_err_o = err_q;

  a_r3_start_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (cnt_a_o == $past(dead_reg) && cnt_b_o == '0 && !down_o && run));
  a_r8_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  a_r8_bad_start_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !legal) |=> (!run && cnt_a_o == '0));
  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!run && cnt_a_o == '0 && cnt_b_o == '0));
endmodule

// File: tb/test_cpwm_timebase.sv
`timescale 1ns/1ps
module test_cpwm_timebase;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, start = 1'b0, clr = 1'b0, wr = 1'b0, addr = 1'b0;
  logic [1:0]  be = 2'b00;
  logic [15:0] wdata = '0;
  logic [15:0] rdata, cnt_a, cnt_b, sub_cnt;
  logic        down, sub_up, turn, cfg_err;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  cpwm_timebase i_cpwm_timebase (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .start_i(start), .clr_i(clr),
    .wr_i(wr), .addr_i(addr), .be_i(be), .wdata_i(wdata), .rdata_o(rdata),
    .cnt_a_o(cnt_a), .cnt_b_o(cnt_b), .sub_cnt_o(sub_cnt), .down_o(down),
    .sub_up_o(sub_up), .turn_o(turn), .cfg_err_o(cfg_err)
  );

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int exp_a(int dt, int cyc, int k);
    int ph = k % (2 * cyc);
    return (ph <= cyc) ? dt + ph : dt + 2 * cyc - ph;
  endfunction

  task automatic step(); @(negedge clk); endtask

  task automatic do_reset();
    rst_n = 1'b0; en = 0; start = 0; clr = 0; wr = 0; be = 0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic write_reg(logic a, logic [15:0] d, logic [1:0] b);
    wr = 1'b1; addr = a; wdata = d; be = b;
    step();
    wr = 1'b0; be = 2'b00;
  endtask

  task automatic read_chk(string what, logic a, int exp);
    addr = a; #1;
    chk(what, rdata, exp);
  endtask

  task automatic start_pulse();
    start = 1'b1; step(); start = 1'b0;
  endtask

  // closed-form profile check at enabled-step index k since start
  task automatic chk_prof(int dt, int cyc, int k);
    int ph = k % (2 * cyc);
    int ea = exp_a(dt, cyc, k);
    int j  = ph - (cyc - dt + 1);
    chk($sformatf("R4 cnt_a k=%0d", k), cnt_a, ea);
    chk($sformatf("R5 cnt_b k=%0d", k), cnt_b, ea - dt);
    chk($sformatf("R4 down k=%0d", k), down, int'(ph > cyc || (ph == 0 && k > 0)));
    chk($sformatf("R6 turn k=%0d", k), turn,
        int'(k > 0 && (ph == cyc + 1 || (ph == 1 && k > 1))));
    if (j >= 0 && j <= 2 * dt) begin
      chk($sformatf("R7 sub k=%0d", k), sub_cnt, (j <= dt) ? cyc + dt - j : cyc + j - dt);
      chk($sformatf("R7 sub_up k=%0d", k), sub_up, int'(j > dt));
    end
  endtask

  task automatic run_prof(int dt, int cyc, int n);
    write_reg(1'b0, 16'(dt), 2'b11);
    write_reg(1'b1, 16'(cyc), 2'b11);
    en = 1'b1;
    start_pulse();
    chk("R3 start cnt_a", cnt_a, dt);
    chk("R3 start cnt_b", cnt_b, 0);
    for (int k = 0; k < n; k++) begin
      chk_prof(dt, cyc, k);
      step();
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1 cnt_a", cnt_a, 0); chk("R1 cnt_b", cnt_b, 0);
    chk("R1 sub", sub_cnt, 0); chk("R1 down", down, 0);
    chk("R1 sub_up", sub_up, 0); chk("R1 turn", turn, 0);
    chk("R1 err", cfg_err, 0);
    read_chk("R1 dead reg", 1'b0, 16'hFFFF);
    read_chk("R1 cycle reg", 1'b1, 16'hFFFF);
  endtask

  task automatic t_partial_writes();
    write_reg(1'b0, 16'h1234, 2'b01);
    read_chk("R2 dead low-byte write ignored", 1'b0, 16'hFFFF);
    write_reg(1'b1, 16'h5678, 2'b10);
    read_chk("R2 cycle high-byte write ignored", 1'b1, 16'hFFFF);
    write_reg(1'b1, 16'h5678, 2'b00);
    read_chk("R2 cycle no-byte write ignored", 1'b1, 16'hFFFF);
    write_reg(1'b0, 16'h0042, 2'b11);
    read_chk("R2 dead full write", 1'b0, 16'h0042);
    read_chk("R2 cycle unchanged", 1'b1, 16'hFFFF);
  endtask

  task automatic t_reset_values_illegal();
    do_reset();
    en = 1'b1;
    start_pulse();
    chk("R8 err after start with reset values", cfg_err, 1);
    repeat (3) step();
    chk("R8 counters stay stopped", cnt_a, 0);
  endtask

  task automatic t_run_hold_write();
    do_reset();
    run_prof(2, 7, 30);
    en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk("R4 hold cnt_a with enable low", cnt_a, exp_a(2, 7, 30));
      chk("R4 hold sub with enable low", sub_cnt, 9);
      step();
    end
    en = 1'b1;
    step();
    chk("R4 resume after enable", cnt_a, exp_a(2, 7, 31));
    write_reg(1'b0, 16'd5, 2'b11);
    write_reg(1'b1, 16'd20, 2'b11);
    chk("R9 cnt_a keeps old profile", cnt_a, exp_a(2, 7, 33));
    chk("R9 cnt_b keeps old offset", cnt_b, exp_a(2, 7, 33) - 2);
    read_chk("R9 new cycle visible on read", 1'b1, 20);
    step();
    chk("R9 cnt_a still old profile", cnt_a, exp_a(2, 7, 34));
    run_prof(5, 20, 45);
  endtask

  task automatic t_clear();
    clr = 1'b1; step(); clr = 1'b0;
    chk("R10 clear cnt_a", cnt_a, 0); chk("R10 clear cnt_b", cnt_b, 0);
    chk("R10 clear down", down, 0);
    repeat (3) step();
    chk("R10 stays stopped", cnt_a, 0);
    start = 1'b1; clr = 1'b1; step(); start = 1'b0; clr = 1'b0;
    repeat (2) step();
    chk("R10 clear beats start", cnt_a, 0);
  endtask

  task automatic t_boundaries();
    run_prof(0, 3, 12);
    run_prof(4, 11, 30);
    write_reg(1'b1, 16'd10, 2'b11);
    start_pulse();
    chk("R8 cycle=2*dead+2 rejected", cfg_err, 1);
    chk("R8 bad start clears cnt_a", cnt_a, 0);
    repeat (3) step();
    chk("R8 bad start keeps stopped", cnt_a, 0);
    run_prof(4, 11, 3);
    chk("R8 error stays set after legal start", cfg_err, 1);
    do_reset();
    chk("R1 error cleared by reset", cfg_err, 0);
    write_reg(1'b0, 16'h0100, 2'b11);
    write_reg(1'b1, 16'hFF00, 2'b11);
    en = 1'b1;
    start_pulse();
    chk("R8 crest overflow rejected", cfg_err, 1);
    chk("R8 overflow start keeps cnt_a zero", cnt_a, 0);
    do_reset();
    run_prof(256, 16'hFEFF, 5);
    chk("R3 crest at 0xFFFF accepted", cfg_err, 0);
  endtask

  initial begin
    t_reset_state();
    t_partial_writes();
    t_reset_values_illegal();
    t_run_hold_write();
    t_clear();
    t_boundaries();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule